// File: doc/BRIEF.md
# Power-On Sequencing Controller

This block decides when a battery-powered system may come up and brings it up in a fixed order. While neither the undervoltage-lockout input nor the thermal-fault input is active, two events can start it. The first is the power key, held low long enough to pass a debounce filter. The second is a valid charger appearing while the system supply is above the lockout level. Once started, the block turns on its default-on regulators one at a time, with a fixed number of clock cycles between steps. It releases the system reset in the same cycle as the last enable, and then waits for the host controller to raise its hold acknowledge.

For a start from the key, the key has to stay pressed until the host acknowledges. If it is released earlier, the regulators are switched off again in reverse order. When the acknowledge arrives, the power-on state is latched and the key no longer matters. A later drop of the hold signal starts an orderly reverse power-off. A lockout or thermal fault in any state drops every enable and asserts reset at the next clock edge.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `uvlo_i` or `therm_i` is high, no sequence starts. A fault seen in any state clears every rail enable, drives `sys_rst_n_o` low and `pwr_on_o` low at the next clock edge, and returns the block to idle.
- R2: The key counts as pressed only after `key_n_i` has been low for DEB_CYC consecutive clock edges. A high level restarts the count. From idle, the sequence starts on the edge after the key counts as pressed.
- R3: A charger start happens only on a rising edge of (`chg_ok_i` AND `vsys_ok_i`) seen in idle. Holding that condition high does not start the block again after a power-off.
- R4: Rails switch on in index order, starting at bit 0 of `rail_en_o`. Rail k switches on (k+1)*STEP_DLY edges after the start edge, and enabled rails stay on while the sequence advances.
- R5: `sys_rst_n_o` stays low until the edge on which the last rail switches on, and goes high on that same edge.
- R6: With reset released, a high `hold_i` sets `pwr_on_o` on the next edge. `pwr_on_o` stays high only while `hold_i` stays high.
- R7: In a key-started sequence, losing the debounced key before the hold acknowledge starts a reverse power-off and asserts reset. A charger-started sequence ignores the key.
- R8: During power-off, one rail switches off every STEP_DLY edges, always the highest-numbered rail that is on. When none is left the block is idle. A low `hold_i` after power-on is latched starts this power-off.
- R9: Once power-on is latched, releasing the key has no effect on any output.
- R10: While `rst_n_i` is low, every rail enable, `sys_rst_n_o` and `pwr_on_o` are low, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| uvlo_i | input | 1 | Undervoltage lockout active (high blocks power) |
| therm_i | input | 1 | Thermal fault active (high blocks power) |
| key_n_i | input | 1 | Power key, low when pressed |
| chg_ok_i | input | 1 | Charger voltage within valid range |
| vsys_ok_i | input | 1 | System voltage above the lockout level |
| hold_i | input | 1 | Hold acknowledge from the host controller |
| rail_en_o | output | NUM_RAILS | Regulator enables, bit 0 first on, last off |
| sys_rst_n_o | output | 1 | System reset, active low |
| pwr_on_o | output | 1 | Power-on state latched |

## Verification
A wrong step count or a broken step timer shows up as a rail enable one or more STEP_DLY windows early or late, so the bench samples `rail_en_o` at the exact edge of each step. A wrong key-source flag or a missing abort path leaves `sys_rst_n_o` high after the key is released, two edges after the release. A fault that does not reach the state register shows up as enables that stay on one edge after `uvlo_i` or `therm_i` rises. A detector that reacts to the charger level instead of its edge restarts the rails right after a power-off, within STEP_DLY edges.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_RAMP_UP,
    PS_WAIT_HOLD,
    PS_ON,
    PS_RAMP_DOWN
  } pwr_state_e;

endpackage

// File: rtl/pwr_key_debounce.sv
module pwr_key_debounce #(
  parameter int DEB_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic key_n_i,
  output logic pressed_o
);
  localparam int CW = $clog2(DEB_CYC + 1);
  localparam logic [CW-1:0] FULL = CW'(DEB_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = key_n_i | (cnt_q != FULL);
    cnt_d  = key_n_i ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pressed_o = (cnt_q == FULL);

  AST_RELEASE_FAST: assert property (@(posedge clk_i) disable iff (!rst_n)
    key_n_i |=> !pressed_o); // R2

endmodule

// File: rtl/pwr_step_timer.sv
module pwr_step_timer #(
  parameter int STEP_DLY = 16
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (STEP_DLY > 2) ? $clog2(STEP_DLY) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEP_DLY - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign tick_o = run_i & (cnt_q == LAST);

  always_comb begin
    cnt_en = run_i | (cnt_q != '0);
    if (clr_i || !run_i || tick_o) cnt_d = '0;
    else                           cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_TICK_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tick_o && !clr_i) |=> !tick_o); // R4

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int NUM_RAILS = 4,
  localparam int IW = $clog2(NUM_RAILS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_n,
  input  logic          fault_i,
  input  logic          key_pressed_i,
  input  logic          chg_start_i,
  input  logic          hold_i,
  input  logic          tick_i,
  output logic          run_o,
  output logic          clr_o,
  output logic [IW-1:0] rails_on_o,
  output logic          sys_rst_n_o,
  output logic          pwr_on_o
);
  localparam logic [IW-1:0] ALL_ON = IW'(NUM_RAILS);

  pwr_state_e    state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          src_key_q, src_key_d;

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    src_key_d = src_key_q;
    if (fault_i) begin
      state_d   = PS_IDLE;
      idx_d     = '0;
      src_key_d = 1'b0;
    end else begin
      unique case (state_q)
        PS_IDLE: begin
          if (key_pressed_i) begin
            state_d   = PS_RAMP_UP;
            src_key_d = 1'b1;
          end else if (chg_start_i) begin
            state_d   = PS_RAMP_UP;
            src_key_d = 1'b0;
          end
        end
        PS_RAMP_UP: begin
          if (src_key_q && !key_pressed_i) begin
            state_d = PS_RAMP_DOWN;
          end else if (tick_i) begin
            idx_d = idx_q + IW'(1);
            if (idx_q == ALL_ON - IW'(1)) state_d = PS_WAIT_HOLD;
          end
        end
        PS_WAIT_HOLD: begin
          if (hold_i)                           state_d = PS_ON;
          else if (src_key_q && !key_pressed_i) state_d = PS_RAMP_DOWN;
        end
        PS_ON: begin
          if (!hold_i) state_d = PS_RAMP_DOWN;
        end
        PS_RAMP_DOWN: begin
          if (idx_q == '0) begin
            state_d = PS_IDLE;
          end else if (tick_i) begin
            idx_d = idx_q - IW'(1);
            if (idx_q == IW'(1)) state_d = PS_IDLE;
          end
        end
        default: begin
          state_d = PS_IDLE;
          idx_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= PS_IDLE;
      idx_q     <= '0;
      src_key_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      idx_q     <= idx_d;
      src_key_q <= src_key_d;
    end
  end

  assign run_o       = (state_q == PS_RAMP_UP) || (state_q == PS_RAMP_DOWN);
  assign clr_o       = (state_d != state_q);
  assign rails_on_o  = idx_q;
  assign sys_rst_n_o = (state_q == PS_WAIT_HOLD) || (state_q == PS_ON);
  assign pwr_on_o    = (state_q == PS_ON);

  AST_FAULT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_n)
    fault_i |=> (idx_q == '0) && !sys_rst_n_o); // R1

  AST_RAIL_STEP: assert property (@(posedge clk_i) disable iff (!rst_n)
    !fault_i |=> (idx_q == $past(idx_q)) || (idx_q == $past(idx_q) + IW'(1))
                 || ($past(idx_q) == idx_q + IW'(1))); // R4

  AST_RST_ALL_RAILS: assert property (@(posedge clk_i) disable iff (!rst_n)
    sys_rst_n_o |-> (idx_q == ALL_ON)); // R5

  AST_ON_NEEDS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(pwr_on_o) |-> $past(hold_i)); // R6

  AST_DOWN_ORDER: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state_q == PS_RAMP_DOWN) |=> (idx_q <= $past(idx_q))); // R8

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int NUM_RAILS = 4,
  parameter int STEP_DLY  = 16,
  parameter int DEB_CYC   = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_n_i,
  input  logic                 uvlo_i,
  input  logic                 therm_i,
  input  logic                 key_n_i,
  input  logic                 chg_ok_i,
  input  logic                 vsys_ok_i,
  input  logic                 hold_i,
  output logic [NUM_RAILS-1:0] rail_en_o,
  output logic                 sys_rst_n_o,
  output logic                 pwr_on_o
);
  localparam int IW = $clog2(NUM_RAILS + 1);

  logic [1:0]    rst_sync_q;
  logic          rst_n;
  logic          fault;
  logic          chg_valid, chg_valid_q, chg_start;
  logic          key_pressed;
  logic          tick, run, clr;
  logic [IW-1:0] rails_on;
  logic          fsm_rst_n, fsm_on;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign fault     = uvlo_i | therm_i;
  assign chg_valid = chg_ok_i & vsys_ok_i;
  assign chg_start = chg_valid & ~chg_valid_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) chg_valid_q <= 1'b0;
    else        chg_valid_q <= chg_valid;
  end

  pwr_key_debounce #(.DEB_CYC(DEB_CYC)) i_debounce (
    .clk_i     (clk_i),
    .rst_n     (rst_n),
    .key_n_i   (key_n_i),
    .pressed_o (key_pressed)
  );

  pwr_step_timer #(.STEP_DLY(STEP_DLY)) i_timer (
    .clk_i  (clk_i),
    .rst_n  (rst_n),
    .run_i  (run),
    .clr_i  (clr),
    .tick_o (tick)
  );

  pwr_seq_fsm #(.NUM_RAILS(NUM_RAILS)) i_fsm (
    .clk_i         (clk_i),
    .rst_n         (rst_n),
    .fault_i       (fault),
    .key_pressed_i (key_pressed),
    .chg_start_i   (chg_start),
    .hold_i        (hold_i),
    .tick_i        (tick),
    .run_o         (run),
    .clr_o         (clr),
    .rails_on_o    (rails_on),
    .sys_rst_n_o   (fsm_rst_n),
    .pwr_on_o      (fsm_on)
  );

  for (genvar k = 0; k < NUM_RAILS; k++) begin : g_rail
    assign rail_en_o[k] = rst_n & (rails_on > IW'(k));
  end

  assign sys_rst_n_o = rst_n & fsm_rst_n;
  assign pwr_on_o    = rst_n & fsm_on;

  AST_ON_WITH_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_n)
    pwr_on_o |-> (sys_rst_n_o && (&rail_en_o))); // R6

  AST_FAULT_OFF: assert property (@(posedge clk_i) disable iff (!rst_n)
    fault |=> (rail_en_o == '0) && !pwr_on_o); // R1

endmodule

// File: tb/test_pwr_seq_ctrl.sv
module test_pwr_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;
  localparam int SD = 8;
  localparam int DB = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          uvlo, therm, key_n, chg_ok, vsys_ok, hold;
  logic [NR-1:0] rail_en;
  logic          sys_rst_n, pwr_on;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwr_seq_ctrl #(.NUM_RAILS(NR), .STEP_DLY(SD), .DEB_CYC(DB)) i_pwr_seq_ctrl (
    .clk_i       (clk),
    .rst_n_i     (rst_n),
    .uvlo_i      (uvlo),
    .therm_i     (therm),
    .key_n_i     (key_n),
    .chg_ok_i    (chg_ok),
    .vsys_ok_i   (vsys_ok),
    .hold_i      (hold),
    .rail_en_o   (rail_en),
    .sys_rst_n_o (sys_rst_n),
    .pwr_on_o    (pwr_on)
  );

  // in = {uvlo, therm, key_n, chg_ok, vsys_ok, hold}; n = edges to wait
  typedef struct packed {
    logic [5:0] in;
    logic [7:0] n;
    logic [3:0] en;
    logic       rst;
    logic       on;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 50;
  localparam vec_t VEC [NV] = '{
    '{6'b001110, 8'd1,  4'b0000, 1'b0, 1'b0, 4'd3},  // R3 charger edge starts
    '{6'b001110, 8'd7,  4'b0000, 1'b0, 1'b0, 4'd4},  // R4 before first step
    '{6'b001110, 8'd1,  4'b0001, 1'b0, 1'b0, 4'd4},  // R4 rail 0
    '{6'b001110, 8'd8,  4'b0011, 1'b0, 1'b0, 4'd4},  // R4 rail 1
    '{6'b001110, 8'd16, 4'b1111, 1'b1, 1'b0, 4'd5},  // R5 release with last rail
    '{6'b001111, 8'd1,  4'b1111, 1'b1, 1'b1, 4'd6},  // R6 hold latches
    '{6'b001111, 8'd20, 4'b1111, 1'b1, 1'b1, 4'd6},  // R6 stays on
    '{6'b001110, 8'd1,  4'b1111, 1'b0, 1'b0, 4'd8},  // R8 hold drop
    '{6'b001110, 8'd8,  4'b0111, 1'b0, 1'b0, 4'd8},  // R8 highest off first
    '{6'b001110, 8'd24, 4'b0000, 1'b0, 1'b0, 4'd8},  // R8 all off
    '{6'b001110, 8'd10, 4'b0000, 1'b0, 1'b0, 4'd3},  // R3 level does not restart
    '{6'b001010, 8'd1,  4'b0000, 1'b0, 1'b0, 4'd3},  // R3
    '{6'b000010, 8'd4,  4'b0000, 1'b0, 1'b0, 4'd2},  // R2 debounce filling
    '{6'b000010, 8'd1,  4'b0000, 1'b0, 1'b0, 4'd2},  // R2 start edge
    '{6'b000010, 8'd8,  4'b0001, 1'b0, 1'b0, 4'd4},  // R4
    '{6'b001010, 8'd1,  4'b0001, 1'b0, 1'b0, 4'd7},  // R7 release seen late
    '{6'b001010, 8'd1,  4'b0001, 1'b0, 1'b0, 4'd7},  // R7 abort
    '{6'b001010, 8'd8,  4'b0000, 1'b0, 1'b0, 4'd7},  // R7 reverse off
    '{6'b000010, 8'd3,  4'b0000, 1'b0, 1'b0, 4'd2},  // R2 short press
    '{6'b001010, 8'd1,  4'b0000, 1'b0, 1'b0, 4'd2},  // R2 bounce
    '{6'b000010, 8'd3,  4'b0000, 1'b0, 1'b0, 4'd2},  // R2 count restarted
    '{6'b000010, 8'd1,  4'b0000, 1'b0, 1'b0, 4'd2},  // R2 pressed now
    '{6'b000010, 8'd17, 4'b0011, 1'b0, 1'b0, 4'd4},  // R4
    '{6'b100010, 8'd1,  4'b0000, 1'b0, 1'b0, 4'd1},  // R1 lockout kills
    '{6'b100010, 8'd10, 4'b0000, 1'b0, 1'b0, 4'd1},  // R1 blocked
    '{6'b010010, 8'd5,  4'b0000, 1'b0, 1'b0, 4'd1},  // R1 thermal blocks
    '{6'b000010, 8'd1,  4'b0000, 1'b0, 1'b0, 4'd1},  // R1 fault clear, start
    '{6'b000010, 8'd32, 4'b1111, 1'b1, 1'b0, 4'd5},  // R5
    '{6'b001010, 8'd1,  4'b1111, 1'b1, 1'b0, 4'd7},  // R7 release seen late
    '{6'b001010, 8'd1,  4'b1111, 1'b0, 1'b0, 4'd7},  // R7 abort before hold
    '{6'b001010, 8'd8,  4'b0111, 1'b0, 1'b0, 4'd8},  // R8
    '{6'b011010, 8'd1,  4'b0000, 1'b0, 1'b0, 4'd1},  // R1 thermal during down
    '{6'b001010, 8'd2,  4'b0000, 1'b0, 1'b0, 4'd1},  // R1
    '{6'b000010, 8'd5,  4'b0000, 1'b0, 1'b0, 4'd2},  // R2
    '{6'b000010, 8'd32, 4'b1111, 1'b1, 1'b0, 4'd5},  // R5
    '{6'b000011, 8'd1,  4'b1111, 1'b1, 1'b1, 4'd6},  // R6
    '{6'b001011, 8'd10, 4'b1111, 1'b1, 1'b1, 4'd9},  // R9 key release ignored
    '{6'b001010, 8'd1,  4'b1111, 1'b0, 1'b0, 4'd8},  // R8
    '{6'b001010, 8'd32, 4'b0000, 1'b0, 1'b0, 4'd8},  // R8
    '{6'b001000, 8'd1,  4'b0000, 1'b0, 1'b0, 4'd3},  // R3
    '{6'b001100, 8'd3,  4'b0000, 1'b0, 1'b0, 4'd3},  // R3 supply low: no start
    '{6'b001111, 8'd9,  4'b0001, 1'b0, 1'b0, 4'd3},  // R3 supply rises: start
    '{6'b001111, 8'd25, 4'b1111, 1'b1, 1'b1, 4'd6},  // R6 early hold
    '{6'b101111, 8'd1,  4'b0000, 1'b0, 1'b0, 4'd1},  // R1 lockout after latch
    '{6'b001010, 8'd2,  4'b0000, 1'b0, 1'b0, 4'd1},  // R1
    '{6'b001110, 8'd1,  4'b0000, 1'b0, 1'b0, 4'd3},  // R3
    '{6'b000110, 8'd8,  4'b0001, 1'b0, 1'b0, 4'd7},  // R7 key has no role
    '{6'b001110, 8'd30, 4'b1111, 1'b1, 1'b0, 4'd7},  // R7 no abort on charger
    '{6'b101010, 8'd1,  4'b0000, 1'b0, 1'b0, 4'd1},  // R1
    '{6'b001010, 8'd1,  4'b0000, 1'b0, 1'b0, 4'd1}   // R1
  };

  task automatic check_out(input int req, input logic [3:0] en_x,
                           input logic rst_x, input logic on_x);
    checks++;
    if (rail_en !== en_x || sys_rst_n !== rst_x || pwr_on !== on_x) begin
      fails++;
      $display("FAIL R%0d: en=%b rst_n=%b on=%b, expected en=%b rst_n=%b on=%b",
               req, rail_en, sys_rst_n, pwr_on, en_x, rst_x, on_x);
    end
  endtask

  task automatic drive(input logic [5:0] v);
    {uvlo, therm, key_n, chg_ok, vsys_ok, hold} = v;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    drive(6'b001010);
    repeat (3) @(negedge clk);
    check_out(10, 4'b0000, 1'b0, 1'b0);   // R10 held in reset
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_out(10, 4'b0000, 1'b0, 1'b0);   // R10 idle after release

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].in);
      repeat (int'(VEC[i].n)) @(negedge clk);
      check_out(int'(VEC[i].req), VEC[i].en, VEC[i].rst, VEC[i].on);
    end

    // R10: reset asserted while powered on clears outputs at once
    drive(6'b001110);
    repeat (33) @(negedge clk);
    check_out(5, 4'b1111, 1'b1, 1'b0);    // R5
    drive(6'b001111);
    @(negedge clk);
    check_out(6, 4'b1111, 1'b1, 1'b1);    // R6
    #1 rst_n = 1'b0;
    #1 check_out(10, 4'b0000, 1'b0, 1'b0); // R10 asynchronous clear
    drive(6'b001010);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (SD + 4) @(negedge clk);
    check_out(10, 4'b0000, 1'b0, 1'b0);   // R10 stays idle

    // R2: key and lockout together never start
    drive(6'b100010);
    repeat (DB + SD + 2) @(negedge clk);
    check_out(1, 4'b0000, 1'b0, 1'b0);    // R1

    finish_run();
  end

endmodule